// File: doc/BRIEF.md
# Clear-on-Read Event Counter Bank

A bank of saturating 16-bit event counters that software reads over an 8-bit microprocessor bus. Each counter accumulates single-cycle pulses from its own event input. Typical sources are far-end block error indications and pseudo-random test-pattern bit errors. Each counter appears as two byte registers. The register holding bits 15:8 sits at the lower address and the register holding bits 7:0 sits at the next address up.

A full count takes two reads. The first read may target either byte. It returns that byte of the live count, clears the whole counter and copies the other byte into one holding register shared by all counters. The second read fetches the saved byte from the holding register's own address. Because the counter is cleared as a whole at the first read, the two bytes always belong to the same sample. Counter 0 is the far-end error counter. It is active only while both mode inputs (cell-interface mode and its framing sub-mode) are asserted.

Top module: `evcnt_bank`

## Requirements
- R1: After reset every counter, the holding register and `rdata_o` are zero.
- R2: Each cycle in which an enabled counter's `ev_i` bit is high adds exactly one to that counter.
- R3: Counter i has its high byte at `BASE_ADDR + 2*i` and its low byte at `BASE_ADDR + 2*i + 1`. The holding register is at `HOLD_ADDR`. The data for a read appears on `rdata_o` in the cycle after `rd_i` rises and stays there until the next read. A read of any other address returns 0x00.
- R4: A read of either byte of a counter returns that byte of the current count and clears all 16 bits of the counter.
- R5: That same read copies the unread byte of the counter into the holding register, and a read at `HOLD_ADDR` returns it.
- R6: Reading the holding register leaves it unchanged. Only a read of a counter byte overwrites it.
- R7: If an event arrives in the same cycle as the clearing read, the counter becomes 1. The returned byte and the saved byte reflect the count without that event.
- R8: A counter at 0xFFFF stays at 0xFFFF when further events arrive.
- R9: Counter 0 counts only while `mode_cell_i` and `mode_plcp_i` are both 1. Otherwise it is held at zero.
- R10: A read strobe that stays high for several cycles acts once, on its first cycle.
- R11: Writes (`wr_i`) to counter or holding addresses change neither the counters nor the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | N_CNT | Event pulses, one bit per counter |
| mode_cell_i | input | 1 | Cell-interface mode selected |
| mode_plcp_i | input | 1 | Framing sub-mode selected |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe (ignored) |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data (ignored) |
| rdata_o | output | 8 | Read data |

## Verification
The hardest case to reach from the ports is an event that lands in the very cycle of the clearing read. The bench raises `ev_i` and `rd_i` on the same falling edge. It then reads the other byte, which returns zero, and then reads the holding register to show that the counter loaded 1. A similar timing case is events arriving while a long read strobe is still high. The bench holds the strobe for several cycles with events during its tail and then reads the counter again. Saturation is reached by holding an event input high for more than 65535 cycles.

// File: rtl/evcnt_bank.sv
module evcnt_bank #(
  parameter int N_CNT = 2,
  parameter int ADDR_W = 16,
  parameter logic [15:0] BASE_ADDR = 16'h115E,
  parameter logic [15:0] HOLD_ADDR = 16'h116C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CNT-1:0]  ev_i,
  input  logic              mode_cell_i,
  input  logic              mode_plcp_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int CW = 16;
  localparam logic [CW-1:0] CMAX = '1;

  logic rd_q;
  logic rd_go;
  logic fe_gate;
  logic [CW-1:0] cnt [N_CNT];
  logic [N_CNT-1:0] hit_hi, hit_lo, clr;
  logic [7:0] hold;
  logic [7:0] rd_byte, keep_byte;
  logic hit_hold;

  wire unused_wr = wr_i ^ (^wdata_i);

  assign rd_go    = rd_i & ~rd_q;
  assign fe_gate  = mode_cell_i & mode_plcp_i;
  assign hit_hold = (addr_i == ADDR_W'(HOLD_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_i;
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(BASE_ADDR + 16'(2 * i));
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(BASE_ADDR + 16'(2 * i + 1));
    logic en, inc;

    assign hit_hi[i] = (addr_i == A_HI);
    assign hit_lo[i] = (addr_i == A_LO);
    assign clr[i]    = rd_go & (hit_hi[i] | hit_lo[i]);
    assign en        = (i == 0) ? fe_gate : 1'b1;
    assign inc       = en & ev_i[i];

    always_ff @(posedge clk) begin
      if (!rst_n || !en)               cnt[i] <= '0;
      else if (clr[i])                 cnt[i] <= {{(CW-1){1'b0}}, inc};
      else if (inc && cnt[i] != CMAX)  cnt[i] <= cnt[i] + 1'b1;
    end

    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt[i] == CMAX && !clr[i]) |=> cnt[i] == CMAX); // R8
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> cnt[i] <= 16'd1); // R4
    if (i == 0) begin : g_gate
      AST_FE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_gate |=> cnt[i] == '0); // R9
    end
  end

  always_comb begin
    rd_byte   = 8'h00;
    keep_byte = 8'h00;
    if (hit_hold) rd_byte = hold;
    for (int i = 0; i < N_CNT; i++) begin
      if (hit_hi[i]) begin
        rd_byte   = cnt[i][15:8];
        keep_byte = cnt[i][7:0];
      end
      if (hit_lo[i]) begin
        rd_byte   = cnt[i][7:0];
        keep_byte = cnt[i][15:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o <= 8'h00;
      hold    <= 8'h00;
    end else if (rd_go) begin
      rdata_o <= rd_byte;
      if (|clr) hold <= keep_byte;
    end
  end

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(|clr) |=> $stable(hold)); // R6
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && rd_q) |=> $stable(rdata_o)); // R10
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rdata_o)); // R3
endmodule

// File: tb/evcnt_bank_tb.sv
module evcnt_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] C0_HI = 16'h115E, C0_LO = 16'h115F;
  localparam logic [15:0] C1_HI = 16'h1160, C1_LO = 16'h1161;
  localparam logic [15:0] HOLD  = 16'h116C;

  logic clk = 0, rst_n = 0;
  logic [1:0] ev_i = '0;
  logic mode_cell_i = 0, mode_plcp_i = 0;
  logic rd_i = 0, wr_i = 0;
  logic [15:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q [$];
  string tag_q [$];

  evcnt_bank u_dut (.clk(clk), .rst_n(rst_n), .ev_i(ev_i), .mode_cell_i(mode_cell_i),
    .mode_plcp_i(mode_plcp_i), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag, input int len = 1);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk); addr_i = a; rd_i = 1;
    repeat (len) @(negedge clk);
    rd_i = 0;
    @(negedge clk);
  endtask

  task automatic events(input int idx, input int n);
    @(negedge clk); ev_i[idx] = 1;
    repeat (n) @(negedge clk);
    ev_i[idx] = 0;
  endtask

  initial begin : monitor
    logic rdl;
    rdl = 0;
    forever begin
      @(posedge clk);
      if (rd_i && !rdl) begin
        rdl = 1;
        @(negedge clk);
        if (exp_q.size() == 0) check("R3 unexpected read", rdata_o, 8'hxx);
        else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end else rdl = rd_i;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", rdata_o, 8'h00);
    rst_n = 1;
    rd(HOLD, 8'h00, "R1 hold after reset");
    rd(C1_LO, 8'h00, "R1 counter after reset");
    events(1, 16'h123);
    rd(C1_HI, 8'h01, "R2 R4 high byte of 0x123");
    rd(HOLD, 8'h23, "R5 saved low byte");
    rd(HOLD, 8'h23, "R6 hold unchanged by hold read");
    rd(C1_LO, 8'h00, "R4 low byte cleared too");
    rd(HOLD, 8'h00, "R5 hold from second clearing read");
    events(1, 16'h2A5);
    rd(C1_LO, 8'hA5, "R4 low-first read");
    rd(HOLD, 8'h02, "R5 saved high byte");
    mode_cell_i = 1; mode_plcp_i = 0;
    events(0, 10);
    rd(C0_LO, 8'h00, "R9 gated with sub-mode off");
    mode_plcp_i = 1;
    events(0, 7);
    rd(C0_LO, 8'h07, "R9 counts with both modes");
    rd(HOLD, 8'h00, "R5 counter0 high byte saved");
    mode_cell_i = 0;
    events(0, 4);
    rd(C0_HI, 8'h00, "R9 gated with cell mode off");
    events(1, 3);
    exp_q.push_back(8'h03); tag_q.push_back("R10 long strobe returns count");
    @(negedge clk); addr_i = C1_LO; rd_i = 1;
    @(negedge clk); ev_i[1] = 1;
    @(negedge clk);
    @(negedge clk); ev_i[1] = 0;
    check("R10 rdata stable during long strobe", rdata_o, 8'h03);
    rd_i = 0;
    @(negedge clk);
    rd(C1_LO, 8'h02, "R10 events during strobe kept");
    events(1, 5);
    exp_q.push_back(8'h05); tag_q.push_back("R7 snapshot excludes coincident event");
    @(negedge clk); addr_i = C1_LO; rd_i = 1; ev_i[1] = 1;
    @(negedge clk); rd_i = 0; ev_i[1] = 0;
    @(negedge clk);
    rd(C1_HI, 8'h00, "R7 high byte after coincident clear");
    rd(HOLD, 8'h01, "R7 counter loaded 1");
    @(negedge clk); addr_i = C1_LO; wdata_i = 8'hFF; wr_i = 1;
    @(negedge clk); addr_i = HOLD; wdata_i = 8'h55;
    @(negedge clk); wr_i = 0;
    rd(HOLD, 8'h01, "R11 hold ignores writes");
    rd(C1_LO, 8'h00, "R11 counter ignores writes");
    rd(16'h1000, 8'h00, "R3 unmapped address reads zero");
    rd(HOLD, 8'h00, "R3 unmapped read leaves hold");
    events(1, 65540);
    rd(C1_HI, 8'hFF, "R8 saturated high byte");
    rd(HOLD, 8'hFF, "R8 saturated low byte");
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule